// File: doc/BRIEF.md
# Status flag and conditional branch unit

This block owns the eight-bit status register of a small 8-bit RISC core. It decodes a 16-bit instruction word, presented with a valid strobe, and handles two instruction families that share one 3-bit flag index. A flag instruction forces one status bit to 1 or to 0. A conditional branch tests one status bit for 1 or for 0 and produces a taken signal, a target address and the next program counter. Named single-flag forms such as set-carry, clear-interrupt, branch-if-equal or branch-if-lower are not separate operations. Each of them is just a fixed value of the shared index.

The ALU computes flags elsewhere. It can overwrite the whole status register through a separate write port. The branch decision is combinational in the cycle the instruction is valid, and it uses the status value held before that cycle's update. For instruction tracing, the block reports the decoded operation kind and the flag index. It also raises a marker when the decoded branch encoding has two mnemonic names: the carry test, which doubles as an unsigned lower or same-or-higher test.

Top module: `flag_branch_unit`

## Requirements
- R1: While `rst_ni` is low, `flags_o` is 0x00.
- R2: A valid word matching 1001 0100 0iii 1000 sets status bit iii at the next clock edge. The bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R3: A valid word matching 1001 0100 1iii 1000 clears status bit iii at the next clock edge and leaves the other seven bits unchanged.
- R4: When `alu_we_i` is high, `flags_o` takes `alu_flags_i` at the next edge, unless a valid set or clear instruction is present in the same cycle. In that case the ALU write is dropped entirely.
- R5: A valid word whose bits 15..10 are 111100 raises `branch_taken_o` in the same cycle exactly when status bit instr[2:0] is 1.
- R6: A valid word whose bits 15..10 are 111101 raises `branch_taken_o` in the same cycle exactly when status bit instr[2:0] is 0.
- R7: For a branch word, `branch_target_o` = pc + 1 + sign-extended instr[9:3], modulo 2^PC_W. `next_pc_o` equals the target when taken and pc + 1 otherwise.
- R8: A word with the strobe low, or a word matching neither family, gives `op_o` = 0 and no branch. It leaves the status register unchanged apart from an ALU write.
- R9: `op_o` reports 0 none, 1 flag set, 2 flag clear, 3 branch-if-set, 4 branch-if-clear. `flag_idx_o` carries the decoded index, or 0 for none. `dual_name_o` is high only for a branch with index 0.
- R10: A branch decision uses the status value from before any ALU write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 16 | Instruction word |
| pc_i | input | PC_W | Program counter of the instruction |
| alu_we_i | input | 1 | ALU status write enable |
| alu_flags_i | input | 8 | ALU status value |
| flags_o | output | 8 | Status register |
| branch_taken_o | output | 1 | Branch taken this cycle |
| branch_target_o | output | PC_W | Branch target address |
| next_pc_o | output | PC_W | Next program counter |
| op_o | output | 3 | Decoded operation kind |
| flag_idx_o | output | 3 | Decoded flag index |
| dual_name_o | output | 1 | Branch encoding has two mnemonic names |

## Verification
The bench builds the block with PC_W = 8, so an 8-bit program counter. This puts target wraparound within reach. A forward branch from 0xFE wraps to 0x02, and the most negative offset from address 0 lands at 0xC1. A scoreboard predicts every output field from the requirements, using an independent model of the status register. The stimulus covers all eight flag indices, an ALU write colliding with a flag instruction, and a branch colliding with an ALU write.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int FLAG_W    = 8;
  localparam int IDX_W     = 3;
  localparam int INSTR_W   = 16;
  localparam int OFF_W     = 7;
  localparam int OFF_LSB   = 3;
  localparam int OP_W      = 3;
  localparam logic [7:0] FLAG_PREFIX = 8'b1001_0100;
  localparam logic [3:0] FLAG_TAIL   = 4'b1000;
  localparam logic [4:0] BR_PREFIX   = 5'b11110;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 3'd0,
    OP_FSET = 3'd1,
    OP_FCLR = 3'd2,
    OP_BSET = 3'd3,
    OP_BCLR = 3'd4
  } fbu_op_e;
endpackage

// File: rtl/fbu_decode.sv
module fbu_decode
  import fbu_pkg::*;
(
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  output fbu_op_e              op_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [OFF_W-1:0]     off_o
);
  always_comb begin
    op_o  = OP_NONE;
    idx_o = '0;
    if (valid_i) begin
      if (instr_i[15:8] == FLAG_PREFIX && instr_i[3:0] == FLAG_TAIL) begin
        op_o  = instr_i[7] ? OP_FCLR : OP_FSET;
        idx_o = instr_i[6:4];
      end else if (instr_i[15:11] == BR_PREFIX) begin
        op_o  = instr_i[10] ? OP_BCLR : OP_BSET;
        idx_o = instr_i[IDX_W-1:0];
      end
    end
  end

  assign off_o = instr_i[OFF_LSB +: OFF_W];
endmodule

// File: rtl/fbu_flag_reg.sv
module fbu_flag_reg
  import fbu_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  fbu_op_e            op_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               alu_we_i,
  input  logic [FLAG_W-1:0]  alu_flags_i,
  output logic [FLAG_W-1:0]  flags_q_o
);
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              flag_hit;

  assign flag_hit = (op_i == OP_FSET) || (op_i == OP_FCLR);

  // flag instruction wins over ALU write for the whole register
  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    always_comb begin
      flags_d[b] = flags_q[b];
      if (flag_hit) begin
        if (idx_i == IDX_W'(b)) flags_d[b] = (op_i == OP_FSET);
      end else if (alu_we_i) begin
        flags_d[b] = alu_flags_i[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_q_o = flags_q;

  assert_set_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FSET) |=> flags_q[$past(idx_i)]);

  assert_clr_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FCLR) |=> !flags_q[$past(idx_i)]);

  // other bits untouched, ALU write dropped
  assert_only_indexed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_hit |=> ((flags_q ^ $past(flags_q)) & ~(FLAG_W'(1) << $past(idx_i))) == '0);

  assert_alu_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_we_i && !flag_hit) |=> flags_q == $past(alu_flags_i));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_we_i && !flag_hit) |=> $stable(flags_q));
endmodule

// File: rtl/fbu_branch.sv
module fbu_branch
  import fbu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  fbu_op_e             op_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [FLAG_W-1:0]   flags_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic [OFF_W-1:0]    off_i,
  output logic                taken_o,
  output logic [PC_W-1:0]     target_o,
  output logic [PC_W-1:0]     next_pc_o
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] pc_inc, off_ext;
  logic            sel_bit;

  assign pc_inc   = pc_i + PC_W'(1);
  assign off_ext  = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign target_o = pc_inc + off_ext;
  assign sel_bit  = flags_i[idx_i];

  always_comb begin
    unique case (op_i)
      OP_BSET: taken_o = sel_bit;
      OP_BCLR: taken_o = !sel_bit;
      default: taken_o = 1'b0;
    endcase
  end

  assign next_pc_o = taken_o ? target_o : pc_inc;
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import fbu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_valid_i,
  input  logic [15:0]         instr_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic                alu_we_i,
  input  logic [7:0]          alu_flags_i,
  output logic [7:0]          flags_o,
  output logic                branch_taken_o,
  output logic [PC_W-1:0]     branch_target_o,
  output logic [PC_W-1:0]     next_pc_o,
  output logic [2:0]          op_o,
  output logic [2:0]          flag_idx_o,
  output logic                dual_name_o
);
  fbu_op_e           op;
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic [FLAG_W-1:0] flags_q;
  logic              is_branch;

  fbu_decode u_decode (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .op_o    (op),
    .idx_o   (idx),
    .off_o   (off)
  );

  fbu_flag_reg u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .idx_i       (idx),
    .alu_we_i    (alu_we_i),
    .alu_flags_i (alu_flags_i),
    .flags_q_o   (flags_q)
  );

  fbu_branch #(.PC_W(PC_W)) u_branch (
    .op_i      (op),
    .idx_i     (idx),
    .flags_i   (flags_q),
    .pc_i      (pc_i),
    .off_i     (off),
    .taken_o   (branch_taken_o),
    .target_o  (branch_target_o),
    .next_pc_o (next_pc_o)
  );

  assign is_branch   = (op == OP_BSET) || (op == OP_BCLR);
  assign flags_o     = flags_q;
  assign op_o        = op;
  assign flag_idx_o  = idx;
  assign dual_name_o = is_branch && (idx == '0);

  assert_bset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BSET) |-> branch_taken_o == flags_o[instr_i[2:0]]);

  assert_bclr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BCLR) |-> branch_taken_o == !flags_o[instr_i[2:0]]);

  assert_fallthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !branch_taken_o |-> next_pc_o == pc_i + PC_W'(1));

  assert_no_branch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> !branch_taken_o && op_o == 3'd0);

  assert_dual_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_name_o |-> instr_i[15:11] == BR_PREFIX && instr_i[2:0] == 3'd0);
endmodule

// File: tb/flag_branch_unit_tb.sv
module flag_branch_unit_tb;
  localparam int PC_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            valid;
  logic [15:0]     instr;
  logic [PC_W-1:0] pc;
  logic            alu_we;
  logic [7:0]      alu_val;
  logic [7:0]      flags;
  logic            taken;
  logic [PC_W-1:0] target, next_pc;
  logic [2:0]      op, fidx;
  logic            dual;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flag_branch_unit #(.PC_W(PC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr),
    .pc_i(pc), .alu_we_i(alu_we), .alu_flags_i(alu_val), .flags_o(flags),
    .branch_taken_o(taken), .branch_target_o(target), .next_pc_o(next_pc),
    .op_o(op), .flag_idx_o(fidx), .dual_name_o(dual)
  );

  typedef struct {
    logic            taken;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] np;
    logic [2:0]      op;
    logic [2:0]      idx;
    logic            dual;
    logic [7:0]      flags;
    string           req;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] mflags;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] w_set(input logic [2:0] i);
    return {8'b1001_0100, 1'b0, i, 4'b1000};
  endfunction
  function automatic logic [15:0] w_clr(input logic [2:0] i);
    return {8'b1001_0100, 1'b1, i, 4'b1000};
  endfunction
  function automatic logic [15:0] w_br(input logic on_clear, input logic [6:0] k, input logic [2:0] i);
    return {5'b11110, on_clear, k, i};
  endfunction

  task automatic drive(input logic v, input logic [15:0] w, input logic [PC_W-1:0] p,
                       input logic we, input logic [7:0] av, input string req);
    exp_t e;
    logic fs, fc, bs, bc;
    logic [PC_W-1:0] inc;
    @(negedge clk);
    valid = v; instr = w; pc = p; alu_we = we; alu_val = av;
    fs  = v && w[15:7] == 9'b1001_0100_0 && w[3:0] == 4'b1000;
    fc  = v && w[15:7] == 9'b1001_0100_1 && w[3:0] == 4'b1000;
    bs  = v && w[15:10] == 6'b111100;
    bc  = v && w[15:10] == 6'b111101;
    inc = p + PC_W'(1);
    e.op     = fs ? 3'd1 : fc ? 3'd2 : bs ? 3'd3 : bc ? 3'd4 : 3'd0;
    e.idx    = (fs || fc) ? w[6:4] : (bs || bc) ? w[2:0] : 3'd0;
    e.taken  = (bs && mflags[w[2:0]]) || (bc && !mflags[w[2:0]]);
    e.target = inc + {{(PC_W-7){w[9]}}, w[9:3]};
    e.np     = e.taken ? e.target : inc;
    e.dual   = (bs || bc) && w[2:0] == 3'd0;
    e.flags  = mflags;
    e.req    = req;
    sb.push_back(e);
    if (fs)      mflags[w[6:4]] = 1'b1;
    else if (fc) mflags[w[6:4]] = 1'b0;
    else if (we) mflags = av;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.req, "flags", {8'h0, flags}, {8'h0, e.flags});
        chk(e.req, "taken", {15'h0, taken}, {15'h0, e.taken});
        chk(e.req, "next_pc", {8'h0, next_pc}, {8'h0, e.np});
        chk(e.req, "op R9", {13'h0, op}, {13'h0, e.op});
        chk(e.req, "idx R9", {13'h0, fidx}, {13'h0, e.idx});
        chk(e.req, "dual R9", {15'h0, dual}, {15'h0, e.dual});
        if (e.op == 3'd3 || e.op == 3'd4)
          chk(e.req, "target R7", {8'h0, target}, {8'h0, e.target});
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; valid = 1'b0; instr = '0; pc = '0; alu_we = 1'b0; alu_val = '0;
    mflags = '0;
    #20;
    chk("R1", "flags in reset", {8'h0, flags}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    // R2: every index
    for (int i = 0; i < 8; i++) drive(1'b1, w_set(3'(i)), 8'(i), 1'b0, 8'h00, "R2");
    // R3: clear only indexed bit
    drive(1'b1, w_clr(3'd3), 8'h30, 1'b0, 8'h00, "R3");
    drive(1'b1, w_clr(3'd7), 8'h31, 1'b0, 8'h00, "R3");
    // R4: ALU write alone, then colliding with a set
    drive(1'b0, 16'h0000, 8'h40, 1'b1, 8'hA5, "R4");
    drive(1'b1, w_set(3'd1), 8'h41, 1'b1, 8'h00, "R4");
    drive(1'b0, 16'h0000, 8'h42, 1'b0, 8'h00, "R4");
    // flags now 0xA7
    drive(1'b1, w_br(1'b0, 7'd5, 3'd1), 8'h10, 1'b0, 8'h00, "R5");
    drive(1'b1, w_br(1'b0, 7'd5, 3'd3), 8'h10, 1'b0, 8'h00, "R5");
    drive(1'b1, w_br(1'b1, 7'h7C, 3'd3), 8'h20, 1'b0, 8'h00, "R6");
    drive(1'b1, w_br(1'b1, 7'd9, 3'd0), 8'h21, 1'b0, 8'h00, "R6 R9");
    drive(1'b1, w_br(1'b0, 7'd3, 3'd0), 8'hFE, 1'b0, 8'h00, "R7");
    drive(1'b1, w_br(1'b1, 7'h40, 3'd4), 8'h00, 1'b0, 8'h00, "R7");
    // R10: branch sees pre-write value
    drive(1'b1, w_br(1'b0, 7'd2, 3'd2), 8'h50, 1'b1, 8'h00, "R10");
    drive(1'b1, w_br(1'b0, 7'd2, 3'd2), 8'h51, 1'b0, 8'h00, "R10");
    drive(1'b1, w_set(3'd6), 8'h52, 1'b0, 8'h00, "R2");
    // R8: ignored words
    drive(1'b0, w_set(3'd5), 8'h60, 1'b0, 8'h00, "R8");
    drive(1'b1, 16'h9459, 8'h61, 1'b0, 8'h00, "R8");
    drive(1'b1, 16'h0000, 8'h62, 1'b0, 8'h00, "R8");
    drive(1'b1, 16'hF800, 8'h63, 1'b0, 8'h00, "R8");
    drive(1'b0, w_br(1'b0, 7'd1, 3'd6), 8'h64, 1'b0, 8'h00, "R8");
    drive(1'b0, 16'h0000, 8'h65, 1'b0, 8'h00, "R8");
    @(negedge clk); valid = 1'b0; alu_we = 1'b0;
    #6;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule